// File: doc/BRIEF.md
# Fs/4 Bandpass Single-Bit Delta-Sigma Modulator

This block turns a stream of signed fixed-point samples into a stream of single bits, one bit per clock, each bit worth +1 or -1 of full scale. In bandpass mode the modulator is a first-order lowpass loop with every storage element replaced by a negated two-sample delay. The noise transfer function 1 - z^-1 therefore becomes 1 + z^-2, and the quantization-noise notch moves from DC to a quarter of the sample rate. A signal near fs/4 passes through and the shaped noise is pushed away from it. A mode input drops the block back to the plain first-order lowpass loop, with its notch at DC.

Two structures are available, chosen by a parameter. The direct structure keeps a two-deep chain of loop residuals. The interleaved structure runs two lowpass loops that take turns on even and odd samples, and negates both input and output with the repeating sign pattern +,+,-,-. Both structures produce the same bit-stream from reset. A downstream filter is expected to pick out the band and bring it to baseband; that filter is not part of this block.

Top module: `p2p_dsm`

## Requirements
- R1: An input code above +2^(W-2) or below -2^(W-2) is treated exactly as +2^(W-2) or -2^(W-2) (±1 full scale).
- R2: While rst_n is low, bit_o is 0 and every loop state register is cleared to zero.
- R3: In lowpass mode (mode_bp_i = 0) the loop computes y(n) = u(n) + r(n-1), where r = y - v. The bit for sample n appears on bit_o at the rising edge that samples u(n). A full-scale positive input in lowpass mode always gives bit_o = 1 on the next edge.
- R4: In bandpass mode (mode_bp_i = 1) the loop computes y(n) = u(n) - r(n-2), where r = y - v, which gives the noise transfer function 1 + z^-2.
- R5: The quantizer gives v = +1 (bit_o = 1) when y >= 0 and v = -1 (bit_o = 0) when y < 0, so y = 0 yields bit_o = 1.
- R6: For inputs within full scale, every stored residual stays within ±1 full scale, so the quantizer never overloads.
- R7: With IMPL set to the interleaved structure, bit_o matches the direct structure sample for sample in either mode from reset. The two copies alternate on even and odd samples, and inputs and outputs are negated on samples 2 and 3 of every group of four.
- R8: In lowpass mode, a constant input u gives a ones density x = (1+u)/2. When x = p/q in lowest terms, bit_o repeats with period q from reset and holds p ones per period.
- R9: In bandpass mode, with input A·c(n) where c(n) = +1 for n mod 4 in {0,1} and -1 otherwise, the sum over N samples of v(n)·c(n) is within 4 of N·A.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock, one input sample per rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_bp_i | input | 1 | 1 selects the fs/4 bandpass loop, 0 the lowpass loop |
| u_i | input | W | Signed input sample; 2^(W-2) is +1 full scale |
| bit_o | output | 1 | Output bit: 1 means +1, 0 means -1 |

## Verification
The modulator has one register stage from input to output. The bit for a sample drives bit_o from the same rising edge that captures that sample. The bench therefore drives each sample on a falling edge and compares bit_o at the next falling edge, before it drives the following sample. Period and density results build up over q samples, and the fs/4 correlation builds up over the whole run. The bench judges these only once the full window has been collected, counting samples from the first edge after reset is released.

// File: rtl/p2p_dsm_pkg.sv
package p2p_dsm_pkg;
   typedef enum logic {
      IMPL_DIRECT      = 1'b0,
      IMPL_INTERLEAVED = 1'b1
   } impl_e;

   localparam int MIN_W = 4;
   localparam int MAX_W = 30;
endpackage

// File: rtl/p2p_dsm_clamp.sv
module p2p_dsm_clamp #(
   parameter int W = 12
) (
   input  logic signed [W-1:0] u_i,
   output logic signed [W-1:0] u_o
);
   localparam int F = W - 2;
   localparam logic signed [W-1:0] FS = W'(1) << F;

   always_comb begin
      if (u_i > FS)       u_o = FS;
      else if (u_i < -FS) u_o = -FS;
      else                u_o = u_i;
   end
endmodule

// File: rtl/p2p_dsm_direct.sv
module p2p_dsm_direct #(
   parameter int W = 12
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                mode_bp_i,
   input  logic signed [W-1:0] u_i,
   output logic                bit_o
);
   localparam int F  = W - 2;
   localparam int YW = W + 1;
   localparam logic signed [YW-1:0] FS = YW'(1) << F;

   logic signed [YW-1:0] u_x;
   logic signed [YW-1:0] r1_q, r2_q;
   logic signed [YW-1:0] y, r_nx;
   logic                 q;

   assign u_x = {u_i[W-1], u_i};

   always_comb begin
      y    = mode_bp_i ? (u_x - r2_q) : (u_x + r1_q);
      q    = ~y[YW-1];
      r_nx = q ? (y - FS) : (y + FS);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         r1_q  <= '0;
         r2_q  <= '0;
         bit_o <= 1'b0;
      end else begin
         r1_q  <= r_nx;
         r2_q  <= r1_q;
         bit_o <= q;
      end
   end

   // R6: stored residual never leaves the full-scale band
   p_resid_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (r1_q <= FS) && (r1_q >= -FS));

   // R6: the older tap is bounded too
   p_resid2_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (r2_q <= FS) && (r2_q >= -FS));
endmodule

// File: rtl/p2p_dsm_interleaved.sv
module p2p_dsm_interleaved #(
   parameter int W = 12
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                mode_bp_i,
   input  logic signed [W-1:0] u_i,
   output logic                bit_o
);
   localparam int F      = W - 2;
   localparam int YW     = W + 1;
   localparam int NCOPY  = 2;
   localparam int PHW    = 2;
   localparam logic signed [YW-1:0] FS = YW'(1) << F;

   logic [PHW-1:0]       ph_q;
   logic signed [YW-1:0] s_q [NCOPY];
   logic signed [YW-1:0] u_x, u_c, s_sel, s_nx, r_nx;
   logic                 neg, sel, qc;

   assign u_x = {u_i[W-1], u_i};

   always_comb begin
      neg   = mode_bp_i & ph_q[1];
      sel   = mode_bp_i & ph_q[0];
      u_c   = neg ? -u_x : u_x;
      s_sel = s_q[sel];
      s_nx  = s_sel + u_c;
      // negated phases break the tie the other way, so the sign flip is exact
      qc    = neg ? (s_nx > 0) : ~s_nx[YW-1];
      r_nx  = qc ? (s_nx - FS) : (s_nx + FS);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_q  <= '0;
         bit_o <= 1'b0;
      end else begin
         ph_q  <= ph_q + 1'b1;
         bit_o <= qc ^ neg;
      end
   end

   for (genvar k = 0; k < NCOPY; k++) begin : g_copy
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                 s_q[k] <= '0;
         else if (sel == k[0])       s_q[k] <= r_nx;
      end

      // R6: each copy's residual stays within full scale
      p_copy_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
         (s_q[k] <= FS) && (s_q[k] >= -FS));

      // R7: a copy not selected for this sample keeps its state
      p_copy_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
         (sel != k[0]) |=> (s_q[k] == $past(s_q[k])));
   end
endmodule

// File: rtl/p2p_dsm.sv
module p2p_dsm #(
   parameter int                 W    = 12,
   parameter p2p_dsm_pkg::impl_e IMPL = p2p_dsm_pkg::IMPL_DIRECT
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                mode_bp_i,
   input  logic signed [W-1:0] u_i,
   output logic                bit_o
);
   localparam int FS_I = 2 ** (W - 2);

   if (W < p2p_dsm_pkg::MIN_W || W > p2p_dsm_pkg::MAX_W) begin : g_bad_w
      $error("p2p_dsm: W out of supported range");
   end

   logic signed [W-1:0] u_lim;

   p2p_dsm_clamp #(.W(W)) u_clamp (
      .u_i (u_i),
      .u_o (u_lim)
   );

   if (IMPL == p2p_dsm_pkg::IMPL_INTERLEAVED) begin : g_ilv
      p2p_dsm_interleaved #(.W(W)) u_core (
         .clk       (clk),
         .rst_n     (rst_n),
         .mode_bp_i (mode_bp_i),
         .u_i       (u_lim),
         .bit_o     (bit_o)
      );
   end else begin : g_dir
      p2p_dsm_direct #(.W(W)) u_core (
         .clk       (clk),
         .rst_n     (rst_n),
         .mode_bp_i (mode_bp_i),
         .u_i       (u_lim),
         .bit_o     (bit_o)
      );
   end

   // R3: lowpass loop at or above full scale must emit +1 on the next edge
   p_fullscale_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!mode_bp_i && (int'(u_i) >= FS_I)) |=> bit_o);

   // R1: a clamped sample never exceeds full scale
   p_clamp_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(u_lim) <= FS_I) && (int'(u_lim) >= -FS_I));
endmodule

// File: tb/sim_p2p_dsm.sv
module sim_p2p_dsm;
   localparam int W  = 12;
   localparam int FS = 2 ** (W - 2);

   logic                clk = 1'b0;
   logic                rst_n = 1'b0;
   logic                mode_bp = 1'b0;
   logic signed [W-1:0] u = '0;
   logic                bit0, bit1;

   int checks = 0;
   int errors = 0;
   int n = 0;
   int mr1 = 0;
   int mr2 = 0;
   int last_bit = 0;
   bit done = 1'b0;

   always #10ns clk = ~clk;

   p2p_dsm #(.W(W), .IMPL(p2p_dsm_pkg::IMPL_DIRECT)) u0 (
      .clk(clk), .rst_n(rst_n), .mode_bp_i(mode_bp), .u_i(u), .bit_o(bit0));

   p2p_dsm #(.W(W), .IMPL(p2p_dsm_pkg::IMPL_INTERLEAVED)) u1 (
      .clk(clk), .rst_n(rst_n), .mode_bp_i(mode_bp), .u_i(u), .bit_o(bit1));

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic int clampv(input int x);
      if (x > FS)  return FS;
      if (x < -FS) return -FS;
      return x;
   endfunction

   task automatic do_reset(input bit bp);
      @(negedge clk);
      rst_n   = 1'b0;
      mode_bp = bp;
      u       = '0;
      repeat (2) @(negedge clk);
      chk(bit0 == 1'b0, "R2", int'(bit0), 0);
      chk(bit1 == 1'b0, "R2", int'(bit1), 0);
      mr1   = 0;
      mr2   = 0;
      n     = 0;
      rst_n = 1'b1;
   endtask

   // drive one sample, compare after the capturing edge, one edge of latency
   task automatic run(input int uval, input string tag);
      int us, y, mb, r;
      u = W'(uval);
      @(posedge clk);
      @(negedge clk);
      us = clampv(uval);
      y  = mode_bp ? (us - mr2) : (us + mr1);
      mb = (y >= 0) ? 1 : 0;
      r  = (mb == 1) ? (y - FS) : (y + FS);
      mr2 = mr1;
      mr1 = r;
      chk(int'(bit0) == mb, tag, int'(bit0), mb);
      chk(bit1 == bit0, "R7", int'(bit1), int'(bit0));
      last_bit = int'(bit0);
      n++;
   endtask

   task automatic period_test(input int uval, input int q, input int p);
      int bits[64];
      int ones, mism;
      do_reset(1'b0);
      for (int i = 0; i < 4 * q; i++) begin
         run(uval, "R3");
         bits[i] = last_bit;
      end
      ones = 0;
      for (int i = 0; i < q; i++) ones += bits[i];
      chk(ones == p, "R8", ones, p);
      mism = 0;
      for (int i = q; i < 4 * q; i++) if (bits[i] != bits[i-q]) mism++;
      chk(mism == 0, "R8", mism, 0);
   endtask

   initial begin
      int lfsr;
      int sum;
      int c;
      int dev;
      int amp;

      // R2 reset state and R5 tie at y = 0
      do_reset(1'b0);
      run(0, "R5");
      chk(last_bit == 1, "R5", last_bit, 1);
      for (int i = 0; i < 15; i++) run(0, "R3");

      // R8 periodic sequences in lowpass mode
      period_test(FS / 2, 4, 3);
      period_test(FS / 4, 8, 5);
      period_test(-3 * FS / 4, 8, 1);
      period_test(0, 2, 1);

      // R3 lowpass ramp through the whole range
      do_reset(1'b0);
      for (int v = -FS; v <= FS; v += 37) run(v, "R3");
      for (int i = 0; i < 20; i++) run(FS, "R3");
      chk(last_bit == 1, "R3", last_bit, 1);

      // R1 over-range codes in both modes
      do_reset(1'b0);
      for (int i = 0; i < 6; i++) run(2 ** (W - 1) - 1, "R1");
      for (int i = 0; i < 20; i++) run(0, "R1");
      for (int i = 0; i < 6; i++) run(-(2 ** (W - 1)), "R1");
      for (int i = 0; i < 20; i++) run(FS / 8, "R1");
      do_reset(1'b1);
      for (int i = 0; i < 8; i++) run(2 ** (W - 1) - 1, "R1");
      for (int i = 0; i < 24; i++) run(0, "R1");

      // R4 bandpass under pseudo-random input
      do_reset(1'b1);
      lfsr = 16'hACE1;
      for (int i = 0; i < 600; i++) begin
         lfsr = {16'(lfsr) >> 1} ^ ((lfsr & 1) != 0 ? 16'hB400 : 16'h0000);
         run((lfsr % (2 * FS + 1)) - FS, "R4");
      end

      // R6 full-scale stress with alternating sign in bandpass
      do_reset(1'b1);
      for (int i = 0; i < 200; i++) run(((i / 3) % 2 == 0) ? FS : -FS, "R6");
      do_reset(1'b0);
      for (int i = 0; i < 100; i++) run((i % 2 == 0) ? FS : -FS, "R6");

      // R9 fs/4 carrier correlation, two amplitudes
      for (int t = 0; t < 2; t++) begin
         amp = (t == 0) ? (3 * FS / 8) : (-5 * FS / 16);
         do_reset(1'b1);
         sum = 0;
         for (int i = 0; i < 2048; i++) begin
            c = ((n % 4) < 2) ? 1 : -1;
            run(amp * c, "R4");
            sum += (last_bit == 1 ? 1 : -1) * c;
         end
         dev = sum * FS - 2048 * amp;
         if (dev < 0) dev = -dev;
         chk(dev <= 4 * FS, "R9", sum * FS, 2048 * amp);
      end

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #4ms;
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual 0 expected 1");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule